// File: doc/BRIEF.md
# Decimal-Capable Add/Subtract Unit

This block is a purely combinational arithmetic slice for an 8-bit accumulator machine. It adds with carry or subtracts with borrow, either as plain binary or as packed binary-coded decimal (two decimal digits per byte). It returns the result byte and four condition flags: negative, overflow, zero and carry.

In decimal mode the flags copy a well-known 8-bit processor's behaviour and are not the "correct" decimal flags. A decimal add takes its zero flag from the plain binary sum. It takes negative and overflow from the high digit before that digit's decimal correction. A decimal subtract reports every flag from the plain binary difference and corrects only the result byte. The surrounding datapath supplies both operands, the incoming carry and the two mode selects. It captures the outputs in its own registers.

The digit count is a parameter (two by default). A second parameter can remove the decimal path entirely, leaving a binary-only unit.

Top module: `bcd_addsub_alu`

## Requirements
- R1: With sub_sel=0 and dec_mode=0, result equals (opa + opb + carry_in) mod 256, and flag_c is 1 exactly when that 9-bit sum exceeds 255.
- R2: With sub_sel=0 and dec_mode=0, flag_v is 1 exactly when opa bit 7 equals opb bit 7 and result bit 7 differs from opa bit 7.
- R3: With sub_sel=1 and dec_mode=0, result equals (opa - opb - (1 - carry_in)) mod 256. flag_c is 1 when no borrow occurs (opa >= opb + 1 - carry_in). flag_v is 1 exactly when opa and opb differ in bit 7 and result bit 7 differs from opa bit 7.
- R4: With dec_mode=0, flag_n equals result bit 7 and flag_z is 1 exactly when result is 0x00.
- R5: With sub_sel=1 clear and dec_mode=1, the low digit is lo = opa[3:0] + opb[3:0] + carry_in, plus 6 when lo > 9. The high digit is hi = opa[7:4] + opb[7:4], plus 1 when the corrected lo exceeds 15, plus 6 when that sum exceeds 9. result = {hi[3:0], lo[3:0]}.
- R6: In decimal add, flag_c is 1 exactly when the corrected high digit of R5 exceeds 15.
- R7: In decimal add, flag_z is 1 exactly when (opa + opb + carry_in) mod 256 is zero. flag_n is bit 3 of the high digit of R5 taken before its +6 correction. flag_v is 1 when that same bit differs from opa bit 7 and opa bit 7 equals opb bit 7.
- R8: With sub_sel=1 and dec_mode=1, lo = opa[3:0] - opb[3:0] - (1 - carry_in); when lo is negative (bit 4 set), 6 is subtracted from lo and 1 from the high digit. hi = opa[7:4] - opb[7:4] (minus that 1); when hi is negative, 6 is subtracted. result = {hi[3:0], lo[3:0]}.
- R9: In decimal subtract, flag_n, flag_z, flag_v and flag_c equal the values R3 and R4 give for the binary difference of the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | Accumulator operand (minuend for subtract) |
| opb | input | 8 | Second operand (subtrahend for subtract) |
| carry_in | input | 1 | Carry into the add; for subtract 1 means no borrow |
| dec_mode | input | 1 | 1 selects packed decimal arithmetic, 0 binary |
| sub_sel | input | 1 | 1 selects subtract with borrow, 0 add with carry |
| result | output | 8 | Result byte |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |

## Verification
The assertions check continuously that the ripple adder agrees with whole-word arithmetic for both add and subtract (R1, R3) and that its overflow follows the sign rule (R2). Whenever both operands are valid decimal, they check that the decimal add and subtract paths produce only valid digits (R5, R8). They also check that the digit borrow chain of a decimal subtract agrees with the binary carry flag (R9). The odd decimal flags (R6, R7) and the exact corrected result bytes, including those for operands that are not valid decimal, can only be shown by the bench. It compares every combination of operands, carry and mode against an independent model, with named corner cases first.

// File: rtl/bas_pkg.sv
`timescale 1ns/1ps
package bas_pkg;
   // width of one packed decimal digit
   localparam int unsigned NIB = 4;
   // largest legal decimal digit and the correction step
   localparam logic [3:0] DEC_MAX = 4'd9;
   localparam logic [3:0] DEC_ADJ = 4'd6;

   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } bas_flags_t;
endpackage

// File: rtl/bas_ripple_adder.sv
`timescale 1ns/1ps
module bas_ripple_adder #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   if (WIDTH < 2) begin : g_width_bad
      $error("bas_ripple_adder: WIDTH must be at least 2");
   end

   logic [WIDTH:0]   cy;
   logic [WIDTH-1:0] opb_eff;

   // subtract is add of the one's complement; carry_in acts as not-borrow
   assign opb_eff = opb ^ {WIDTH{sub}};
   assign cy[0]   = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic half;
      assign half      = opa[i] ^ opb_eff[i];
      assign sum[i]    = half ^ cy[i];
      assign cy[i+1]   = (opa[i] & opb_eff[i]) | (cy[i] & half);
   end

   assign cout = cy[WIDTH];
   assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];

   always_comb begin
      if (!sub) begin
         // R1
         add_sum_chk: assert ({cout, sum} ==
            ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin}))
            else $error("ripple add disagrees with word add");
      end else begin
         // R3
         sub_diff_chk: assert ((sum == (opa - opb - {{(WIDTH-1){1'b0}}, ~cin})) &&
            (cout == ({1'b0, opa} >= ({1'b0, opb} + {{WIDTH{1'b0}}, ~cin}))))
            else $error("ripple subtract disagrees with word subtract");
      end
      // R2
      no_overflow_chk: assert (ovf ==
         ((opa[WIDTH-1] == (opb[WIDTH-1] ^ sub)) && (sum[WIDTH-1] != opa[WIDTH-1])))
         else $error("overflow does not follow sign rule");
   end
endmodule

// File: rtl/bas_bcd_add.sv
`timescale 1ns/1ps
module bas_bcd_add #(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned WIDTH = DIGITS * bas_pkg::NIB
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout,
   output logic             top_raw_b3
);
   import bas_pkg::*;

   if (DIGITS < 1) begin : g_digits_bad
      $error("bas_bcd_add: DIGITS must be at least 1");
   end

   // carry between digits, taken from the corrected digit
   logic [DIGITS:0] dc;
   assign dc[0] = cin;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [4:0] raw;
      logic [5:0] adj;
      assign raw = {1'b0, opa[i*NIB +: NIB]} + {1'b0, opb[i*NIB +: NIB]} + {4'b0, dc[i]};
      assign adj = (raw > {1'b0, DEC_MAX}) ? ({1'b0, raw} + {2'b0, DEC_ADJ})
                                           : {1'b0, raw};
      assign dc[i+1]          = |adj[5:4];
      assign res[i*NIB +: NIB] = adj[3:0];
   end

   assign cout       = dc[DIGITS];
   // uncorrected top digit bit 3 feeds the negative and overflow flags
   assign top_raw_b3 = g_dig[DIGITS-1].raw[3];

   logic in_ok, out_ok;
   always_comb begin
      in_ok  = 1'b1;
      out_ok = 1'b1;
      for (int k = 0; k < DIGITS; k++) begin
         if (opa[k*NIB +: NIB] > DEC_MAX || opb[k*NIB +: NIB] > DEC_MAX) in_ok = 1'b0;
         if (res[k*NIB +: NIB] > DEC_MAX) out_ok = 1'b0;
      end
      // R5
      add_digit_valid_chk: assert (!in_ok || out_ok)
         else $error("decimal add produced a non-decimal digit");
   end
endmodule

// File: rtl/bas_bcd_sub.sv
`timescale 1ns/1ps
module bas_bcd_sub #(
   parameter int unsigned DIGITS = 2,
   localparam int unsigned WIDTH = DIGITS * bas_pkg::NIB
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             borrow_out
);
   import bas_pkg::*;

   if (DIGITS < 1) begin : g_digits_bad
      $error("bas_bcd_sub: DIGITS must be at least 1");
   end

   // borrow between digits comes from the sign of the raw digit difference
   logic [DIGITS:0] bw;
   assign bw[0] = ~cin;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      logic [4:0] raw;
      assign raw = {1'b0, opa[i*NIB +: NIB]} - {1'b0, opb[i*NIB +: NIB]} - {4'b0, bw[i]};
      assign bw[i+1] = raw[4];
      assign res[i*NIB +: NIB] = raw[4] ? (raw[3:0] - DEC_ADJ) : raw[3:0];
   end

   assign borrow_out = bw[DIGITS];

   logic in_ok, out_ok;
   always_comb begin
      in_ok  = 1'b1;
      out_ok = 1'b1;
      for (int k = 0; k < DIGITS; k++) begin
         if (opa[k*NIB +: NIB] > DEC_MAX || opb[k*NIB +: NIB] > DEC_MAX) in_ok = 1'b0;
         if (res[k*NIB +: NIB] > DEC_MAX) out_ok = 1'b0;
      end
      // R8
      sub_digit_valid_chk: assert (!in_ok || out_ok)
         else $error("decimal subtract produced a non-decimal digit");
   end
endmodule

// File: rtl/bcd_addsub_alu.sv
`timescale 1ns/1ps
module bcd_addsub_alu #(
   parameter int unsigned DIGITS = 2,
   parameter bit          BCD_EN = 1'b1,
   localparam int unsigned WIDTH = DIGITS * bas_pkg::NIB
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             carry_in,
   input  logic             dec_mode,
   input  logic             sub_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_v,
   output logic             flag_z,
   output logic             flag_c
);
   import bas_pkg::*;

   if (DIGITS < 1 || DIGITS > 8) begin : g_digits_bad
      $error("bcd_addsub_alu: DIGITS must be between 1 and 8");
   end

   logic [WIDTH-1:0] bin_sum;
   logic             bin_cout;
   logic             bin_ovf;
   bas_flags_t       flg;

   // binary path always runs: its flags serve binary mode and decimal subtract
   bas_ripple_adder #(.WIDTH(WIDTH)) u_bin (
      .opa (opa),
      .opb (opb),
      .cin (carry_in),
      .sub (sub_sel),
      .sum (bin_sum),
      .cout(bin_cout),
      .ovf (bin_ovf)
   );

   if (BCD_EN) begin : g_dec
      logic [WIDTH-1:0] add_res;
      logic [WIDTH-1:0] sub_res;
      logic             add_cout;
      logic             add_top_b3;
      logic             sub_borrow;

      bas_bcd_add #(.DIGITS(DIGITS)) u_dadd (
         .opa       (opa),
         .opb       (opb),
         .cin       (carry_in),
         .res       (add_res),
         .cout      (add_cout),
         .top_raw_b3(add_top_b3)
      );

      bas_bcd_sub #(.DIGITS(DIGITS)) u_dsub (
         .opa       (opa),
         .opb       (opb),
         .cin       (carry_in),
         .res       (sub_res),
         .borrow_out(sub_borrow)
      );

      always_comb begin
         result = bin_sum;
         flg.n  = bin_sum[WIDTH-1];
         flg.v  = bin_ovf;
         flg.z  = ~|bin_sum;
         flg.c  = bin_cout;
         if (dec_mode) begin
            if (sub_sel) begin
               result = sub_res;
            end else begin
               result = add_res;
               flg.n  = add_top_b3;
               flg.v  = (add_top_b3 ^ opa[WIDTH-1]) & ~(opa[WIDTH-1] ^ opb[WIDTH-1]);
               flg.c  = add_cout;
            end
         end
      end

      always_comb begin
         if (dec_mode && sub_sel) begin
            // R9
            dec_borrow_chk: assert (sub_borrow == ~flag_c)
               else $error("decimal borrow chain disagrees with carry flag");
         end
      end
   end else begin : g_bin
      always_comb begin
         result = bin_sum;
         flg.n  = bin_sum[WIDTH-1];
         flg.v  = bin_ovf;
         flg.z  = ~|bin_sum;
         flg.c  = bin_cout;
      end
   end

   assign flag_n = flg.n;
   assign flag_v = flg.v;
   assign flag_z = flg.z;
   assign flag_c = flg.c;
endmodule

// File: tb/bcd_addsub_alu_tb_top.sv
`timescale 1ns/1ps
module bcd_addsub_alu_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [7:0] opa = '0, opb = '0;
   logic carry_in = 1'b0, dec_mode = 1'b0, sub_sel = 1'b0;
   logic [7:0] result;
   logic flag_n, flag_v, flag_z, flag_c;

   bcd_addsub_alu dut_i (
      .opa(opa), .opb(opb), .carry_in(carry_in), .dec_mode(dec_mode),
      .sub_sel(sub_sel), .result(result), .flag_n(flag_n), .flag_v(flag_v),
      .flag_z(flag_z), .flag_c(flag_c)
   );

   typedef struct {
      logic [7:0] res;
      logic n, v, z, c;
      string tr, tc, tv, tnz, what;
   } exp_t;

   exp_t exp_q[$];
   event smp_ev;
   int checks = 0, errors = 0, shown = 0, cycles = 0;
   bit done = 1'b0;

   function automatic exp_t model(int a, int b, int ci, int dec, int sb);
      exp_t e;
      int t, lo, hi, r;
      if (sb == 0 && dec == 0) begin
         t = a + b + ci; r = t & 255;
         e.c = (t > 255); e.v = (((a ^ b) & 128) == 0) && (((a ^ r) & 128) != 0);
         e.n = r[7]; e.z = (r == 0);
         e.tr = "R1"; e.tc = "R1"; e.tv = "R2"; e.tnz = "R4";
      end else if (sb != 0) begin
         t = a - b - (1 - ci); r = t & 255;
         e.c = (t >= 0); e.v = (((a ^ b) & 128) != 0) && (((a ^ r) & 128) != 0);
         e.n = r[7]; e.z = (r == 0);
         if (dec != 0) begin
            lo = (a & 15) - (b & 15) - (1 - ci);
            hi = (a >> 4) - (b >> 4);
            if (lo < 0) begin lo = lo - 6; hi = hi - 1; end
            if (hi < 0) hi = hi - 6;
            r = ((hi & 15) << 4) | (lo & 15);
            e.tr = "R8"; e.tc = "R9"; e.tv = "R9"; e.tnz = "R9";
         end else begin
            e.tr = "R3"; e.tc = "R3"; e.tv = "R3"; e.tnz = "R4";
         end
      end else begin
         lo = (a & 15) + (b & 15) + ci;
         if (lo > 9) lo = lo + 6;
         hi = (a >> 4) + (b >> 4) + ((lo > 15) ? 1 : 0);
         e.z = (((a + b + ci) & 255) == 0);
         e.n = hi[3];
         e.v = ((((hi << 4) ^ a) & 128) != 0) && (((a ^ b) & 128) == 0);
         if (hi > 9) hi = hi + 6;
         e.c = (hi > 15);
         r = ((hi & 15) << 4) | (lo & 15);
         e.tr = "R5"; e.tc = "R6"; e.tv = "R7"; e.tnz = "R7";
      end
      e.res = r[7:0];
      return e;
   endfunction

   task automatic drive(int a, int b, int ci, int dec, int sb, string what);
      exp_t e;
      opa = a[7:0]; opb = b[7:0];
      carry_in = ci[0]; dec_mode = dec[0]; sub_sel = sb[0];
      e = model(a, b, ci, dec, sb);
      e.what = what;
      exp_q.push_back(e);
      #0.25;
      ->smp_ev;
      #0.25;
   endtask

   function automatic void report(string tag, string fld, string what, int got, int exp);
      if (shown < 40) begin
         $display("FAIL %s %s (%s) a=%h b=%h ci=%0d dec=%0d sub=%0d: got %h expected %h",
                  tag, fld, what, opa, opb, carry_in, dec_mode, sub_sel, got, exp);
         shown++;
      end
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   // monitor: pops the expected item for each settled vector and compares
   initial begin
      forever begin
         exp_t e;
         bit bad;
         @(smp_ev);
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1 scoreboard: got 0 items expected 1");
            continue;
         end
         e = exp_q.pop_front();
         bad = 1'b0;
         if (result !== e.res) begin bad = 1'b1; report(e.tr,  "result", e.what, int'(result), int'(e.res)); end
         if (flag_c !== e.c)   begin bad = 1'b1; report(e.tc,  "carry",  e.what, int'(flag_c), int'(e.c)); end
         if (flag_v !== e.v)   begin bad = 1'b1; report(e.tv,  "ovf",    e.what, int'(flag_v), int'(e.v)); end
         if (flag_n !== e.n)   begin bad = 1'b1; report(e.tnz, "neg",    e.what, int'(flag_n), int'(e.n)); end
         if (flag_z !== e.z)   begin bad = 1'b1; report(e.tnz, "zero",   e.what, int'(flag_z), int'(e.z)); end
         if (bad) errors++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000 && !done) begin
         errors++;
         $display("FAIL watchdog all requirements: got hang expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #0.1;
      // R4 reset/idle state: all-zero inputs give zero result, Z set
      drive(8'h00, 8'h00, 0, 0, 0, "reset state R4");
      // R1 R2 binary add corners
      drive(8'h7F, 8'h01, 0, 0, 0, "R2 positive overflow");
      drive(8'hFF, 8'h01, 0, 0, 0, "R1 carry wrap to zero");
      drive(8'h80, 8'h80, 0, 0, 0, "R2 negative overflow");
      drive(8'hFF, 8'hFF, 1, 0, 0, "R1 max with carry");
      // R3 binary subtract corners
      drive(8'h00, 8'h01, 1, 0, 1, "R3 borrow wrap");
      drive(8'h80, 8'h01, 1, 0, 1, "R3 subtract overflow");
      drive(8'h05, 8'h05, 0, 0, 1, "R3 borrow in");
      // R5 R6 R7 decimal add quirks
      drive(8'h58, 8'h46, 1, 1, 0, "R6 decimal carry out");
      drive(8'h99, 8'h01, 0, 1, 0, "R7 Z clear on zero decimal byte");
      drive(8'h50, 8'hB0, 0, 1, 0, "R7 Z set by binary sum");
      drive(8'h09, 8'h09, 1, 1, 0, "R5 low digit fixup");
      drive(8'h79, 8'h00, 1, 1, 0, "R7 N and V from unfixed digit");
      // R8 R9 decimal subtract
      drive(8'h00, 8'h01, 1, 1, 1, "R8 wrap to 99");
      drive(8'h10, 8'h01, 1, 1, 1, "R8 nibble borrow");
      drive(8'h46, 8'h12, 0, 1, 1, "R9 borrow in");
      // every operand, carry and mode combination
      for (int m = 0; m < 8; m++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               drive(a, b, m & 1, (m >> 1) & 1, (m >> 2) & 1, "sweep");
            end
         end
      end
      #1;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule